// File: doc/BRIEF.md
# USB Frame Start Timer

This block paces the frames of a full-speed USB host controller. It counts cycles of the 12 MHz frame clock and raises a one-cycle start-of-frame strobe on the last cycle of each frame. The frame length is a fixed base of 11936 clocks plus a 7-bit adjustment that software programs. Software uses the adjustment to trim the frame rate against the accuracy of the clock source. After either reset the adjustment is 64, which gives a 12000-clock (1 ms) frame.

The adjustment is held in a shadow register that software can write and read back at any time. The value in the shadow is copied into the active period only when a frame wraps. A rewrite therefore never stretches or cuts the frame in progress. A run input starts and stops the timer. An 11-bit frame number advances on every strobe.

Top module: `usb_sof_timer`

## Requirements
- R1: After `rst` the block reads back 8'h40 on `rd_data`, `frame_num` is 0 and `sof` is low.
- R2: While running, consecutive `sof` pulses are exactly 11936 + A clock cycles apart, where A is the active adjustment taken from bits 6:0 of the written byte (range 11936 to 12063).
- R3: With the reset-default adjustment, consecutive `sof` pulses are 12000 cycles apart.
- R4: `rd_data` returns {1'b0, A_w}, where A_w is the most recently written adjustment (the shadow, not the active value). It is visible the cycle after the write, and bit 7 always reads 0 whatever was written to it.
- R5: A write during a frame leaves that frame's length unchanged and sets the length of the frame that follows. This includes a write presented in the same cycle as `sof`, which sets the frame starting just after it.
- R6: `sof` is never high in two consecutive cycles.
- R7: While `run` is low, `sof` stays low, `frame_num` holds and the count stays at zero. When `run` rises, the first `sof` comes L-1 clock edges after the first edge that samples `run` high, where L uses the adjustment written last (also during the stop).
- R8: `frame_num` increments by one on the clock edge that ends a `sof` cycle, and wraps from 2047 to 0.
- R9: `glb_rst` acts like `rst`: the adjustment returns to 64, `frame_num` clears and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz frame clock |
| rst | input | 1 | Host-controller reset, synchronous, active high |
| glb_rst | input | 1 | Global reset, synchronous, active high |
| run | input | 1 | High: timer counts; low: held at zero |
| wr_en | input | 1 | Write strobe for the adjustment register |
| wr_data | input | 8 | Write byte; bits 6:0 adjustment, bit 7 ignored |
| rd_data | output | 8 | Read-back of the shadow adjustment, bit 7 zero |
| sof | output | 1 | One-cycle start-of-frame strobe |
| frame_num | output | 11 | Frame number, advances on each strobe |

## Verification
The strobe is decoded from the counter without a register, so it is high during the cycle in which the count reaches the period minus one. The frame number changes one edge later, and a write shows on `rd_data` one edge after the cycle that presents it. The bench drives inputs and samples outputs on falling edges. It measures each frame as the number of falling edges from one strobe to the next, which makes the expected counts 11936 + A between strobes and one less for the first frame after start or reset. A second instance built with a short base period sweeps the frame number through its wrap within the run time.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;

    localparam int ADJ_W        = 7;
    localparam int REG_W        = 8;
    localparam int FNUM_W       = 11;
    localparam int BASE_LEN_DEF = 11936;

    typedef logic [ADJ_W-1:0]  adj_t;
    typedef logic [FNUM_W-1:0] fnum_t;

    localparam adj_t ADJ_RST = adj_t'(64);

    typedef enum logic {
        TMR_STOP = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_mode_t;

    function automatic logic [REG_W-1:0] adj_to_reg(adj_t a);
        return {{(REG_W-ADJ_W){1'b0}}, a};
    endfunction

endpackage

// File: rtl/sof_adj_reg.sv
module sof_adj_reg
    import usb_sof_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output adj_t             shadow,
    output adj_t             next_adj
);

    adj_t wr_adj;
    logic unused_rsvd;

    assign wr_adj      = wr_data[ADJ_W-1:0];
    assign unused_rsvd = ^wr_data[REG_W-1:ADJ_W];

    always_ff @(posedge clk) begin
        if (clr) begin
            shadow <= ADJ_RST;
        end else if (wr_en) begin
            shadow <= wr_adj;
        end
    end

    // A write in the wrap cycle is forwarded so it governs the next frame.
    assign next_adj = wr_en ? wr_adj : shadow;

endmodule

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr
    import usb_sof_pkg::*;
#(
    parameter int BASE_LEN = BASE_LEN_DEF,
    parameter int CNT_W    = 14
)(
    input  logic      clk,
    input  logic      clr,
    input  tmr_mode_t mode,
    input  adj_t      next_adj,
    output logic      sof
);

    localparam logic [CNT_W-1:0] BASE_M1 = CNT_W'(BASE_LEN - 1);

    adj_t             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             at_last;

    assign last    = BASE_M1 + CNT_W'(active);
    assign at_last = (cnt == last);
    assign sof     = (mode == TMR_RUN) && at_last;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt    <= '0;
            active <= ADJ_RST;
        end else if (mode == TMR_STOP) begin
            cnt    <= '0;
            active <= next_adj;
        end else if (at_last) begin
            cnt    <= '0;
            active <= next_adj;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sof_frame_num.sv
module sof_frame_num
    import usb_sof_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  sof,
    output fnum_t fnum
);

    always_ff @(posedge clk) begin
        if (clr) begin
            fnum <= '0;
        end else if (sof) begin
            fnum <= fnum + 1'b1;
        end
    end

endmodule

// File: rtl/usb_sof_timer.sv
module usb_sof_timer
    import usb_sof_pkg::*;
#(
    parameter int BASE_LEN = BASE_LEN_DEF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_rst,
    input  logic              run,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              sof,
    output logic [FNUM_W-1:0] frame_num
);

    localparam int LEN_MAX = BASE_LEN + (1 << ADJ_W) - 1;
    localparam int CNT_W   = $clog2(LEN_MAX);

    logic      clr;
    adj_t      shadow;
    adj_t      next_adj;
    tmr_mode_t mode;

    assign clr  = rst | glb_rst;
    assign mode = run ? TMR_RUN : TMR_STOP;

    sof_adj_reg u_adj (
        .clk      (clk),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .shadow   (shadow),
        .next_adj (next_adj)
    );

    sof_frame_ctr #(
        .BASE_LEN (BASE_LEN),
        .CNT_W    (CNT_W)
    ) u_ctr (
        .clk      (clk),
        .clr      (clr),
        .mode     (mode),
        .next_adj (next_adj),
        .sof      (sof)
    );

    sof_frame_num u_fnum (
        .clk  (clk),
        .clr  (clr),
        .sof  (sof),
        .fnum (frame_num)
    );

    assign rd_data = adj_to_reg(shadow);

endmodule

// File: rtl/usb_sof_timer_chk.sv
module usb_sof_timer_chk
    import usb_sof_pkg::*;
#(
    parameter int BASE_LEN = BASE_LEN_DEF
)(
    input logic              clk,
    input logic              rst,
    input logic              glb_rst,
    input logic              run,
    input logic [REG_W-1:0]  rd_data,
    input logic              sof,
    input logic [FNUM_W-1:0] frame_num
);

    int gap;

    always_ff @(posedge clk) begin
        if (rst || glb_rst || !run || sof) begin
            gap <= 0;
        end else begin
            gap <= gap + 1;
        end
    end

    // R1 R9
    reset_default_chk: assert property (@(posedge clk)
        (rst || glb_rst) |=> (rd_data == adj_to_reg(ADJ_RST)) && (frame_num == '0));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst || glb_rst)
        rd_data[REG_W-1] == 1'b0);

    // R6
    sof_single_chk: assert property (@(posedge clk) disable iff (rst || glb_rst)
        sof |=> !sof);

    // R2
    frame_span_chk: assert property (@(posedge clk) disable iff (rst || glb_rst)
        sof |-> (gap >= BASE_LEN - 1) && (gap <= BASE_LEN + (1 << ADJ_W) - 2));

    // R8
    fnum_step_chk: assert property (@(posedge clk) disable iff (rst || glb_rst)
        sof |=> frame_num == FNUM_W'($past(frame_num) + 1'b1));

    // R7
    fnum_hold_chk: assert property (@(posedge clk) disable iff (rst || glb_rst)
        !sof |=> $stable(frame_num));

endmodule

bind usb_sof_timer usb_sof_timer_chk #(.BASE_LEN(BASE_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .glb_rst   (glb_rst),
    .run       (run),
    .rd_data   (rd_data),
    .sof       (sof),
    .frame_num (frame_num)
);

// File: tb/usb_sof_timer_tb.sv
`timescale 1ns/1ps
module usb_sof_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        glb_rst = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        sof;
    logic [10:0] frame_num;

    logic        w_run = 1'b0;
    logic        w_wr = 1'b0;
    logic [7:0]  w_data = 8'h00;
    logic [7:0]  w_rd;
    logic        w_sof;
    logic [10:0] w_fnum;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    usb_sof_timer u_dut (
        .clk(clk), .rst(rst), .glb_rst(glb_rst), .run(run),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sof(sof), .frame_num(frame_num)
    );

    usb_sof_timer #(.BASE_LEN(8)) u_wrap (
        .clk(clk), .rst(rst), .glb_rst(1'b0), .run(w_run),
        .wr_en(w_wr), .wr_data(w_data), .rd_data(w_rd),
        .sof(w_sof), .frame_num(w_fnum)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Counts falling edges until sof is seen; optionally writes at edge wr_at.
    task automatic frame_gap(input int wr_at, input logic [7:0] d, output int n);
        n = 0;
        if (wr_at == 0) begin wr_en = 1'b1; wr_data = d; end
        do begin
            @(negedge clk);
            n++;
            if (n == wr_at) begin wr_en = 1'b1; wr_data = d; end
            else wr_en = 1'b0;
        end while (!sof && n < 13000);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 rd_data", int'(rd_data), 8'h40);
        chk("R1 frame_num", int'(frame_num), 0);
        chk("R1 sof", int'(sof), 0);
    endtask

    task automatic t_default;
        int n;
        run = 1'b1;
        frame_gap(-1, 8'h00, n);
        chk("R7 first frame after start", n, 11999);
        frame_gap(-1, 8'h00, n);
        chk("R3 default frame", n, 12000);
        @(negedge clk);
        chk("R6 sof one cycle", int'(sof), 0);
        chk("R8 frame_num after two strobes", int'(frame_num), 2);
    endtask

    task automatic t_adjust;
        int n;
        frame_gap(100, 8'h00, n);
        chk("R5 frame with mid write unchanged", n, 11999);
        frame_gap(-1, 8'h00, n);
        chk("R2 adj 0 frame", n, 11936);
        chk("R4 readback 0", int'(rd_data), 0);
        frame_gap(0, 8'hFF, n);
        chk("R5 write on sof cycle sets next frame", n, 12063);
        chk("R4 bit7 dropped", int'(rd_data), 8'h7F);
    endtask

    task automatic t_stop;
        int n;
        int hits = 0;
        logic [10:0] f0;
        @(negedge clk);
        run = 1'b0;
        f0 = frame_num;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sof) hits++;
            if (i == 50) begin wr_en = 1'b1; wr_data = 8'h0A; end
            else wr_en = 1'b0;
        end
        chk("R7 no sof while stopped", hits, 0);
        chk("R7 frame_num holds", int'(frame_num), int'(f0));
        chk("R4 readback while stopped", int'(rd_data), 8'h0A);
        run = 1'b1;
        frame_gap(-1, 8'h00, n);
        chk("R7 restart with written adj", n, 11945);
    endtask

    task automatic t_glb;
        int n;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h05;
        @(negedge clk);
        wr_en = 1'b0; glb_rst = 1'b1;
        @(negedge clk);
        glb_rst = 1'b0;
        chk("R9 rd_data default", int'(rd_data), 8'h40);
        chk("R9 frame_num cleared", int'(frame_num), 0);
        frame_gap(-1, 8'h00, n);
        chk("R9 count restarts", n, 11999);
    endtask

    task automatic t_wrap;
        int k = 0;
        int cyc = 0;
        @(negedge clk);
        w_wr = 1'b1; w_data = 8'h00;
        @(negedge clk);
        w_wr = 1'b0; w_run = 1'b1;
        while (k < 2048 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (w_sof) k++;
        end
        chk("R8 frame_num at last strobe", int'(w_fnum), 2047);
        @(negedge clk);
        chk("R8 frame_num wraps", int'(w_fnum), 0);
    endtask

    initial begin
        t_reset();
        t_default();
        t_adjust();
        t_stop();
        t_glb();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule